// File: doc/BRIEF.md
# Byte-In, Word-Out Receive FIFO with Data Request

This block sits between a serial audio receiver and a downstream word buffer. The receiver hands it one byte per cycle with a valid strobe and no back-pressure. The block stores up to 32 bytes and offers them downstream as 16-bit words, two bytes per word, with the earlier byte in the upper half. Whenever at least two bytes are held, a word is on offer, and the consumer takes it with a ready strobe.

A transfer engine watches a data-request output. The request is raised from a programmable fill condition. That condition is either "fill level at or above a threshold", with the threshold set in steps of eight bytes, or "completely full". Software can turn the request off. It can also restrict the request to the time during which an external packet byte counter is non-zero. An interrupt follows the same fill condition under its own enable. A byte that arrives while the store is full is dropped and sets a sticky overflow flag, which a status read clears. A single control write can also empty the store and its word packer at once.

Top module: `byte_fifo_dreq`

## Requirements
- R1: After reset the fill level is 0, no word is offered, and the request, interrupt and overflow outputs are 0. All stored control fields are 0.
- R2: A byte presented with `byteValid` while the fill level is below 32 is stored. `fillLevel` reports the number of bytes held, from 0 to 32.
- R3: A byte presented while the fill level is 32 is dropped, and `overflow` becomes 1 at the next edge. The flag stays 1 until a cycle with `statusRead` high in which no new overflow occurs. A new overflow in the same cycle as a read wins.
- R4: `wordValid` is 1 exactly when at least 2 bytes are held. `wordData[15:8]` is the oldest byte and `wordData[7:0]` the next one. A cycle with `wordValid` and `wordReady` both high removes both bytes.
- R5: The threshold condition is met when the fill level is non-zero and at least 8 times the threshold field, `ctrlWdata[12:8]`. A field of 0 is therefore met by any non-empty store, and a field above 4 is never met.
- R6: With the full-select bit `ctrlWdata[1]` set, the fill condition is met only when the fill level is 32.
- R7: While the request-enable bit `ctrlWdata[0]` is 0, `dmaReq` is 0. While it is 1, `dmaReq` follows the selected fill condition, subject to R8.
- R8: With the packet-gate bit `ctrlWdata[2]` set, `dmaReq` is 0 whenever `pktCountNz` is 0. With it clear, `pktCountNz` has no effect.
- R9: `irq` equals the interrupt-enable bit `ctrlWdata[3]` ANDed with the selected fill condition. It does not depend on request enable or packet gating.
- R10: A control write with the flush bit `ctrlWdata[4]` set leaves the store empty after that edge. A byte or word removal in the same cycle is discarded, and no overflow is raised. The flush bit is not stored, so later writes without it do not empty the store.
- R11: In a cycle with both a byte accepted and a word removed, the fill level changes by -1. Byte order is kept across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Receiver byte strobe |
| byteData | input | 8 | Receiver byte |
| wordReady | input | 1 | Downstream takes the offered word |
| wordValid | output | 1 | A word is on offer |
| wordData | output | 16 | Offered word, oldest byte in the upper half |
| ctrlWe | input | 1 | Control write strobe |
| ctrlWdata | input | 16 | Control write value (fields in R5 to R10) |
| pktCountNz | input | 1 | External packet byte counter is non-zero |
| statusRead | input | 1 | Status read strobe, clears overflow |
| fillLevel | output | 6 | Bytes held |
| dmaReq | output | 1 | Data request to the transfer engine |
| irq | output | 1 | Fill-condition interrupt |
| overflow | output | 1 | Sticky overflow flag |

## Verification
A fill with no consumer drives the store through every threshold step up to full and then into overflow. This separates the ">=" compare from an off-by-one compare and the full mode from the threshold mode. Draining one word at a time at threshold 0 and with full-select shows where each condition drops. A flush that coincides with a byte and a pop, and a status read that coincides with a new overflow, settle the two priority rules. A long stretch of random push, pop, gating and control writes, compared cycle by cycle against a queue model, covers simultaneous push and pop and pointer wrap.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;
  // control write field positions
  localparam int CTL_W        = 16;
  localparam int CTL_REQ_EN   = 0;
  localparam int CTL_REQ_FULL = 1;
  localparam int CTL_PKT_GATE = 2;
  localparam int CTL_IRQ_EN   = 3;
  localparam int CTL_FLUSH    = 4;
  localparam int CTL_THR_LSB  = 8;
  localparam int THR_W        = 5;
  // threshold field counts fill level in steps of 2**THR_SHIFT bytes
  localparam int THR_SHIFT    = 3;

  typedef struct packed {
    logic reqEnable;
    logic reqOnFull;
    logic pktGate;
    logic irqEnable;
    logic [THR_W-1:0] thrField;
  } fifo_ctrl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifo_strobe_t;
endpackage

// File: rtl/byte_fifo_store.sv
module byte_fifo_store
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int BYTE_W = 8,
  parameter int BPW    = 2,
  localparam int AW     = $clog2(DEPTH),
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int WORD_W = BYTE_W * BPW
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifo_strobe_t      stb,
  input  logic [BYTE_W-1:0] byteIn,
  output logic [LVL_W-1:0]  fillLevel,
  output logic [WORD_W-1:0] wordOut
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [LVL_W-1:0]  fillQ, fillNext;

  always_comb begin
    fillNext = fillQ;
    if (stb.push) fillNext = fillNext + LVL_W'(1);
    if (stb.pop)  fillNext = fillNext - LVL_W'(BPW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fillQ <= '0;
    end else if (stb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fillQ <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + AW'(1);
      if (stb.pop)  rdPtr <= rdPtr + AW'(BPW);
      fillQ <= fillNext;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push && !stb.clear) mem[wrPtr] <= byteIn;
  end

  // word packer: oldest byte lands in the most significant lane
  for (genvar g = 0; g < BPW; g++) begin : g_lane
    assign wordOut[(BPW-1-g)*BYTE_W +: BYTE_W] = mem[rdPtr + AW'(g)];
  end

  assign fillLevel = fillQ;

  // R2: level never exceeds the store size
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    fillQ <= LVL_W'(DEPTH));
  // R3: control never pushes into a full store
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> fillQ != LVL_W'(DEPTH));
  // R4, R11: a pop removes exactly one word's worth of bytes
  p_pop_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && !stb.clear) |=>
      (int'(fillQ) + BPW == int'($past(fillQ)) + int'($past(stb.push))));
  // R10: clear leaves the store empty
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> fillQ == '0);
endmodule

// File: rtl/byte_fifo_ctrl.sv
module byte_fifo_ctrl
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int BPW   = 2,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int CMP_W = (LVL_W > THR_W + THR_SHIFT) ? LVL_W : THR_W + THR_SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic             wordReady,
  input  logic             ctrlWe,
  input  logic [CTL_W-1:0] ctrlWdata,
  input  logic             pktCountNz,
  input  logic             statusRead,
  input  logic [LVL_W-1:0] fillLevel,
  output fifo_strobe_t     stb,
  output logic             wordValid,
  output logic             dmaReq,
  output logic             irq,
  output logic             overflow
);
  fifo_ctrl_t ctrlQ;
  logic       ovfQ;
  logic       flushNow, isFull, isEmpty, dropByte;
  logic       thrMet, condMet, reqAllowed;
  logic [CMP_W-1:0] fillExt, thrExt;

  assign flushNow = ctrlWe && ctrlWdata[CTL_FLUSH];
  assign isFull   = (fillLevel == LVL_W'(DEPTH));
  assign isEmpty  = (fillLevel == '0);
  assign wordValid = (fillLevel >= LVL_W'(BPW));

  assign stb.clear = flushNow;
  assign stb.push  = byteValid && !isFull && !flushNow;
  assign stb.pop   = wordValid && wordReady && !flushNow;
  assign dropByte  = byteValid && isFull && !flushNow;

  // threshold compare in widened arithmetic
  assign fillExt = CMP_W'(fillLevel);
  assign thrExt  = CMP_W'({ctrlQ.thrField, {THR_SHIFT{1'b0}}});
  assign thrMet  = !isEmpty && (fillExt >= thrExt);
  assign condMet = ctrlQ.reqOnFull ? isFull : thrMet;

  assign reqAllowed = !ctrlQ.pktGate || pktCountNz;
  assign dmaReq     = ctrlQ.reqEnable && condMet && reqAllowed;
  assign irq        = ctrlQ.irqEnable && condMet;
  assign overflow   = ovfQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWe) begin
      ctrlQ.reqEnable <= ctrlWdata[CTL_REQ_EN];
      ctrlQ.reqOnFull <= ctrlWdata[CTL_REQ_FULL];
      ctrlQ.pktGate   <= ctrlWdata[CTL_PKT_GATE];
      ctrlQ.irqEnable <= ctrlWdata[CTL_IRQ_EN];
      ctrlQ.thrField  <= ctrlWdata[CTL_THR_LSB +: THR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           ovfQ <= 1'b0;
    else if (dropByte)   ovfQ <= 1'b1;
    else if (statusRead) ovfQ <= 1'b0;
  end

  // R3: flag holds without a read
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !statusRead) |=> overflow);
  // R3: a byte offered to a full store raises the flag
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && isFull && !ctrlWe) |=> overflow);
  // R7: disabled request stays low
  p_req_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.reqEnable |-> !dmaReq);
  // R8: gated request needs a live packet count
  p_req_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.pktGate && !pktCountNz) |-> !dmaReq);
  // R9: interrupt only while enabled and never from an empty store
  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ctrlQ.irqEnable && !isEmpty));
endmodule

// File: rtl/byte_fifo_dreq.sv
module byte_fifo_dreq
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int BYTE_W = 8,
  parameter int BPW    = 2,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int WORD_W = BYTE_W * BPW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              wordReady,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  input  logic              ctrlWe,
  input  logic [CTL_W-1:0]  ctrlWdata,
  input  logic              pktCountNz,
  input  logic              statusRead,
  output logic [LVL_W-1:0]  fillLevel,
  output logic              dmaReq,
  output logic              irq,
  output logic              overflow
);
  fifo_strobe_t stb;

  byte_fifo_ctrl #(.DEPTH(DEPTH), .BPW(BPW)) u_ctrl (
    .clk, .rstN, .byteValid, .wordReady, .ctrlWe, .ctrlWdata,
    .pktCountNz, .statusRead, .fillLevel, .stb, .wordValid,
    .dmaReq, .irq, .overflow
  );

  byte_fifo_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .BPW(BPW)) u_store (
    .clk, .rstN, .stb, .byteIn(byteData), .fillLevel, .wordOut(wordData)
  );
endmodule

// File: tb/test_byte_fifo_dreq.sv
`timescale 1ns/1ps
module test_byte_fifo_dreq;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, byteValid, wordReady, wordValid, ctrlWe, pktCountNz, statusRead;
  logic dmaReq, irq, overflow;
  logic [7:0]  byteData;
  logic [15:0] wordData, ctrlWdata;
  logic [5:0]  fillLevel;

  byte_fifo_dreq i_byte_fifo_dreq (
    .clk, .rstN, .byteValid, .byteData, .wordReady, .wordValid, .wordData,
    .ctrlWe, .ctrlWdata, .pktCountNz, .statusRead, .fillLevel,
    .dmaReq, .irq, .overflow
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0] q[$];
  bit mReqEn, mFull, mGate, mIrqEn, mOvf;
  int mThr;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit expCond();
    if (mFull) return q.size() == DEPTH;
    return q.size() != 0 && q.size() >= mThr * 8;
  endfunction

  task automatic compareAll();
    string rtag;
    bit c;
    c = expCond();
    check("R2", "fillLevel", int'(fillLevel), q.size());
    check("R4", "wordValid", int'(wordValid), int'(q.size() >= 2));
    if (q.size() >= 2) check("R4", "wordData", int'(wordData), int'({q[0], q[1]}));
    if (!mReqEn) rtag = "R7";
    else if (mGate && !pktCountNz) rtag = "R8";
    else if (mFull) rtag = "R6";
    else rtag = "R5";
    check(rtag, "dmaReq", int'(dmaReq), int'(mReqEn && c && (!mGate || pktCountNz)));
    check("R9", "irq", int'(irq), int'(mIrqEn && c));
    check("R3", "overflow", int'(overflow), int'(mOvf));
  endtask

  function automatic logic [15:0] mkCtrl(bit en, bit full, bit gate, bit ien, bit flush, int thr);
    logic [15:0] v;
    v = '0;
    v[0] = en; v[1] = full; v[2] = gate; v[3] = ien; v[4] = flush;
    v[12:8] = thr[4:0];
    return v;
  endfunction

  // one clock: check current outputs, drive next inputs, advance the model
  task automatic cyc(bit bv, logic [7:0] bd, bit rdy, bit we, logic [15:0] wd, bit pkt, bit sr);
    int sz;
    bit fl, ovfSet;
    @(negedge clk);
    compareAll();
    byteValid = bv; byteData = bd; wordReady = rdy;
    ctrlWe = we; ctrlWdata = wd; pktCountNz = pkt; statusRead = sr;
    sz = q.size();
    fl = we && wd[4];
    if (we) begin
      mReqEn = wd[0]; mFull = wd[1]; mGate = wd[2]; mIrqEn = wd[3];
      mThr = int'(wd[12:8]);
    end
    ovfSet = bv && sz == DEPTH && !fl;
    if (fl) q.delete();
    else begin
      if (rdy && sz >= 2) begin
        void'(q.pop_front());
        void'(q.pop_front());
      end
      if (bv && sz < DEPTH) q.push_back(bd);
    end
    if (ovfSet) mOvf = 1'b1;
    else if (sr) mOvf = 1'b0;
  endtask

  task automatic idle(int n, bit pkt);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 16'h0, pkt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] nb;
    rstN = 0; byteValid = 0; byteData = 0; wordReady = 0; ctrlWe = 0;
    ctrlWdata = 0; pktCountNz = 0; statusRead = 0;
    mReqEn = 0; mFull = 0; mGate = 0; mIrqEn = 0; mOvf = 0; mThr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "fillLevel", int'(fillLevel), 0);
    check("R1", "wordValid", int'(wordValid), 0);
    check("R1", "dmaReq", int'(dmaReq), 0);
    check("R1", "irq", int'(irq), 0);
    check("R1", "overflow", int'(overflow), 0);
    rstN = 1;

    // R5, R9: threshold 16 bytes, request and interrupt on; fill with no consumer
    cyc(0, 8'h00, 0, 1, mkCtrl(1, 0, 0, 1, 0, 2), 1, 0);
    nb = 8'h10;
    for (int i = 0; i < 34; i++) begin cyc(1, nb, 0, 0, 16'h0, 1, 0); nb++; end
    // R3: overflow sticky, then read with concurrent overflow, then plain read
    idle(3, 1);
    cyc(1, 8'hEE, 0, 0, 16'h0, 1, 1);
    idle(2, 1);
    cyc(0, 8'h00, 0, 0, 16'h0, 1, 1);
    idle(2, 1);
    // R6: full-select mode, drain one word at a time
    cyc(0, 8'h00, 0, 1, mkCtrl(1, 1, 0, 1, 0, 0), 1, 0);
    idle(2, 1);
    for (int i = 0; i < 16; i++) begin cyc(0, 8'h00, 1, 0, 16'h0, 1, 0); idle(1, 1); end
    // R5: threshold 0 with a single byte; threshold 5 never met
    cyc(0, 8'h00, 0, 1, mkCtrl(1, 0, 0, 1, 0, 0), 1, 0);
    cyc(1, 8'hA5, 0, 0, 16'h0, 1, 0);
    idle(2, 1);
    cyc(0, 8'h00, 0, 1, mkCtrl(1, 0, 0, 1, 0, 5), 1, 0);
    for (int i = 0; i < 34; i++) cyc(1, 8'(i), 0, 0, 16'h0, 1, 0);
    // R8: packet gating with count zero and non-zero
    cyc(0, 8'h00, 0, 1, mkCtrl(1, 0, 1, 1, 0, 1), 0, 0);
    idle(3, 0);
    idle(3, 1);
    idle(2, 0);
    // R7, R9: request disabled, interrupt still follows the condition
    cyc(0, 8'h00, 0, 1, mkCtrl(0, 0, 0, 1, 0, 1), 1, 0);
    idle(3, 1);
    // R10: flush together with a byte, a pop and a would-be overflow
    cyc(1, 8'h77, 1, 1, mkCtrl(1, 0, 0, 1, 1, 0), 1, 0);
    idle(2, 1);
    cyc(1, 8'h31, 0, 0, 16'h0, 1, 0);
    cyc(1, 8'h32, 0, 0, 16'h0, 1, 0);
    cyc(1, 8'h33, 0, 1, mkCtrl(1, 0, 0, 1, 0, 0), 1, 0);
    idle(2, 1);
    cyc(0, 8'h00, 1, 0, 16'h0, 1, 0);
    idle(2, 1);

    // R11: random mix of push, pop, gating, reads and control writes
    for (int i = 0; i < 4000; i++) begin
      bit we;
      logic [15:0] wd;
      we = ($urandom % 60) == 0;
      wd = mkCtrl(1'($urandom), 1'($urandom % 4 == 0), 1'($urandom),
                  1'($urandom), 1'($urandom % 4 == 0), int'($urandom % 6));
      cyc(1'($urandom % 3 != 0), 8'($urandom), 1'($urandom % 5 < 2), we, wd,
          1'($urandom % 4 != 0), 1'($urandom % 25 == 0));
    end
    idle(2, 1);
    summary();
    $finish;
  end
endmodule